// File: doc/BRIEF.md
# Four-Wire Full-Duplex Byte Slave

This block is the slave side of a four-wire serial link: an active-low select, a serial clock, a data input and a data output. While select is low, one byte moves in and one byte moves out at the same time, most significant bit first. All four pins are sampled from a faster system clock through synchronizer stages, so the serial clock must be much slower than the system clock.

On the falling edge of select the block loads the transmit byte and puts its top bit on the data output at once. Each rising serial clock edge shifts one received bit into the receive register. Each falling serial clock edge advances the output by one bit. Once all bits of the transmit byte have been sent, the output repeats the received bits in the order they came in, starting with the first one.

When select rises, the receive register is handed over on a parallel output with a one-cycle strobe. A short burst lands right-aligned, with zeros above it. A long burst keeps only the most recent byte's worth of bits. A transfer with no clocks produces no strobe. The data output is always actively driven.

Top module: `duplex_byte_slave`

## Requirements
- R1: After synchronous reset, `sdo` is 0 and `rx_valid` is 0.
- R2: After `ss_n` falls, and before any serial clock edge, `sdo` carries bit BYTE_W-1 of `tx_byte`. That bit is sampled when the falling select edge is detected.
- R3: `sdo` changes only after a falling `sck` edge while selected, or after a falling `ss_n` edge. Before the k-th rising `sck` edge (k counted from 0, k < BYTE_W), `sdo` carries bit BYTE_W-1-k of the loaded transmit byte.
- R4: `sdi` is sampled on rising `sck` edges, MSB first. After exactly BYTE_W clocks, `rx_data` equals the bits in arrival order, with the first bit in bit BYTE_W-1.
- R5: After n clocks with 0 < n < BYTE_W, `rx_data` holds the n received bits in bits n-1..0, the first bit in bit n-1, and zeros above them.
- R6: After more than BYTE_W clocks, `rx_data` holds only the last BYTE_W received bits, the oldest in bit BYTE_W-1.
- R7: Before the k-th rising `sck` edge with k >= BYTE_W, `sdo` carries received bit k-BYTE_W, counted from 0 in arrival order.
- R8: Each transfer with at least one clock gives exactly one `rx_valid` pulse, one system clock wide, shortly after `ss_n` rises. `rx_data` holds its value until the next pulse.
- R9: A transfer with no `sck` rising edge gives no `rx_valid` pulse.
- R10: While `ss_n` is high, `sck` and `sdi` activity is ignored: `sdo` keeps its last value and no `rx_valid` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be much faster than `sck` |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Active-low select; a transfer lasts while it is low |
| sck | input | 1 | Serial clock; idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, always driven |
| tx_byte | input | BYTE_W | Byte to send; sampled when select falls |
| rx_data | output | BYTE_W | Last received byte, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when a non-empty transfer ends |

## Verification
The bench builds the block with BYTE_W = 4 and SYNC_STAGES = 2. The narrow byte makes it practical to sweep every pairing of transmit byte and received byte in full four-bit transfers. The same width means a sweep of burst lengths from zero to twice the byte width covers short right-aligned bursts, exact bursts, and long bursts where truncation and echo both apply. Expected received values and expected output bits come from shift arithmetic in the bench.

// File: rtl/dbs_pkg.sv
// Shared types for the four-wire byte slave.
// Assumes: nothing beyond standard SystemVerilog.
package dbs_pkg;

    // Pin events, already synchronized to the system clock.
    typedef struct packed {
        logic sel_fall;  // select has just become active
        logic sel_rise;  // select has just been released
        logic clk_rise;  // serial clock rising while selected
        logic clk_fall;  // serial clock falling while selected
        logic active;    // select currently low
        logic din;       // synchronized data-in level
    } dbs_evt_t;

endpackage

// File: rtl/dbs_sync_chain.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: each pin is a level signal, slow compared with clk.
// STAGES must be at least 1.
module dbs_sync_chain #(
    parameter int WIDTH   = 3,
    parameter int STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Move the pins one stage down the chain on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_out = stg[STAGES-1];

endmodule

// File: rtl/dbs_edge_unit.sv
// Turns synchronized select and clock levels into single-cycle events.
// Assumes: inputs come from dbs_sync_chain. Serial clock edges are
// reported only while select is active.
module dbs_edge_unit
    import dbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ss_s,
    input  logic     sck_s,
    input  logic     sdi_s,
    output dbs_evt_t evt
);

    logic ss_p;
    logic sck_p;

    // Keep the previous level of select and clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_p  <= 1'b1;
            sck_p <= 1'b0;
        end else begin
            ss_p  <= ss_s;
            sck_p <= sck_s;
        end
    end

    // Decode the edges; clock edges are gated by select.
    always_comb begin
        evt.active   = ~ss_s;
        evt.sel_fall = ~ss_s &  ss_p;
        evt.sel_rise =  ss_s & ~ss_p;
        evt.clk_rise = ~ss_s &  sck_s & ~sck_p;
        evt.clk_fall = ~ss_s & ~sck_s &  sck_p;
        evt.din      = sdi_s;
    end

endmodule

// File: rtl/dbs_rx_path.sv
// Receive side: shifts sampled bits in on rising clock events, counts
// them (saturating at BYTE_W) and releases the byte with a strobe when
// select is released. The count clears whenever select is inactive.
// Assumes: events come from dbs_edge_unit.
module dbs_rx_path
    import dbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbs_evt_t          evt,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              last_bit
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] sr;

    // Shift register: cleared at the start of a transfer, fills from the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (evt.sel_fall) begin
            sr <= '0;
        end else if (evt.clk_rise) begin
            sr <= {sr[BYTE_W-2:0], evt.din};
        end
    end

    // Bit counter: held at zero while idle, saturates at one full byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (!evt.active || evt.sel_fall) begin
            bit_cnt <= '0;
        end else if (evt.clk_rise && bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Hand-off: strobe and latch the byte when a non-empty transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (evt.sel_rise && bit_cnt != '0) begin
                rx_valid <= 1'b1;
                rx_data  <= sr;
            end
        end
    end

    assign last_bit = sr[0];

endmodule

// File: rtl/dbs_tx_path.sv
// Transmit side: loads the byte on select falling, presents its MSB at
// once, and advances one bit per falling clock event. The vacated LSB is
// filled with the most recently received bit, so once the transmit byte
// is exhausted the output repeats the received stream.
// Assumes: echo_bit is the receive register LSB, valid at the falling event.
module dbs_tx_path
    import dbs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dbs_evt_t          evt,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              echo_bit,
    output logic              sdo
);

    logic [BYTE_W-1:0] sr;

    // Output register: loads on select fall, shifts on clock fall, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (evt.sel_fall) begin
            sr <= tx_byte;
        end else if (evt.clk_fall) begin
            sr <= {sr[BYTE_W-2:0], echo_bit};
        end
    end

    assign sdo = sr[BYTE_W-1];

endmodule

// File: rtl/duplex_byte_slave.sv
// Four-wire full-duplex byte slave, sampled from a fast system clock.
// Assumes: sck idles low and toggles at least SYNC_STAGES+2 system clocks
// apart; ss_n and sck edges are not simultaneous.
module duplex_byte_slave
    import dbs_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    dbs_evt_t         evt;
    logic [CNT_W-1:0] bit_cnt;
    logic             echo_bit;

    // Named event wires, visible to the bound checker.
    logic ev_sel_fall, ev_sel_rise, ev_clk_fall, ev_active;
    assign ev_sel_fall = evt.sel_fall;
    assign ev_sel_rise = evt.sel_rise;
    assign ev_clk_fall = evt.clk_fall;
    assign ev_active   = evt.active;

    dbs_sync_chain #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({ss_n, sck, sdi}),
        .q_out(pins_s)
    );

    dbs_edge_unit u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .ss_s (pins_s[2]),
        .sck_s(pins_s[1]),
        .sdi_s(pins_s[0]),
        .evt  (evt)
    );

    dbs_rx_path #(
        .BYTE_W(BYTE_W),
        .CNT_W (CNT_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .rx_data (rx_data),
        .rx_valid(rx_valid),
        .bit_cnt (bit_cnt),
        .last_bit(echo_bit)
    );

    dbs_tx_path #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .tx_byte (tx_byte),
        .echo_bit(echo_bit),
        .sdo     (sdo)
    );

endmodule

// File: rtl/dbs_checker.sv
// Protocol checker for duplex_byte_slave, attached with bind below.
// Assumes: connected to the slave's named event wires and bit counter.
module dbs_checker #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_fall,
    input logic              sel_rise,
    input logic              clk_fall,
    input logic              active,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              sdo,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              rx_valid
);

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall |=> (sdo == $past(tx_byte[BYTE_W-1])));

    assert_sdo_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_fall && !clk_fall) |=> $stable(sdo));

    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_strobe_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sel_rise));

    assert_no_strobe_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && bit_cnt == '0) |=> !rx_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(sdo));

    assert_idle_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_cnt == '0));

endmodule

bind duplex_byte_slave dbs_checker #(
    .BYTE_W(BYTE_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_fall(ev_sel_fall),
    .sel_rise(ev_sel_rise),
    .clk_fall(ev_clk_fall),
    .active  (ev_active),
    .bit_cnt (bit_cnt),
    .sdo     (sdo),
    .tx_byte (tx_byte),
    .rx_valid(rx_valid)
);

// File: tb/sim_duplex_byte_slave.sv
module sim_duplex_byte_slave;

    localparam int W       = 4;
    localparam int CLK_P   = 10;
    localparam int SETTLE  = 6;
    localparam int WD_LIM  = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ss_n = 1'b1;
    logic         sck = 1'b0;
    logic         sdi = 1'b0;
    logic         sdo;
    logic [W-1:0] tx_byte = '0;
    logic [W-1:0] rx_data;
    logic         rx_valid;

    int n_checks = 0;
    int n_errors = 0;
    int pulses   = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    duplex_byte_slave #(.BYTE_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .tx_byte(tx_byte), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // Count strobes seen at the port.
    always @(posedge clk) if (rst_n && rx_valid) pulses <= pulses + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transfer of n clocks; bits[i] is the i-th bit sent on sdi.
    task automatic xfer(input int n, input logic [W-1:0] tx, input logic [31:0] bits);
        int p0;
        logic [W-1:0] exp_rx;
        logic exp_bit;
        p0 = pulses;
        exp_rx = '0;
        tx_byte = tx;
        ss_n = 1'b0;
        wait_n(SETTLE);
        check(sdo == tx[W-1], "R2 first bit", int'(sdo), int'(tx[W-1]));
        for (int i = 0; i < n; i++) begin
            sdi = bits[i];
            wait_n(SETTLE);
            exp_bit = (i < W) ? tx[W-1-i] : bits[i-W];
            if (i < W) check(sdo == exp_bit, "R3 tx bit", int'(sdo), int'(exp_bit));
            else       check(sdo == exp_bit, "R7 echo bit", int'(sdo), int'(exp_bit));
            sck = 1'b1;
            wait_n(SETTLE);
            check(sdo == exp_bit, "R3 no change on rise", int'(sdo), int'(exp_bit));
            sck = 1'b0;
            wait_n(SETTLE);
            exp_rx = {exp_rx[W-2:0], bits[i]};
        end
        ss_n = 1'b1;
        wait_n(SETTLE + 2);
        if (n == 0) begin
            check(pulses == p0, "R9 no strobe", pulses - p0, 0);
        end else begin
            check(pulses == p0 + 1, "R8 one strobe", pulses - p0, 1);
            if (n < W)       check(rx_data == exp_rx, "R5 short", int'(rx_data), int'(exp_rx));
            else if (n == W) check(rx_data == exp_rx, "R4 full", int'(rx_data), int'(exp_rx));
            else             check(rx_data == exp_rx, "R6 long", int'(rx_data), int'(exp_rx));
        end
    endtask

    initial begin
        logic held;
        logic [W-1:0] held_rx;
        int p0;
        wait_n(4);
        // R1: reset state
        check(sdo == 1'b0, "R1 sdo", int'(sdo), 0);
        check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        wait_n(4);
        check(pulses == 0, "R1 no strobe", pulses, 0);

        // R4/R3: every transmit byte against every received byte
        for (int t = 0; t < (1 << W); t++) begin
            for (int r = 0; r < (1 << W); r++) begin
                logic [31:0] b;
                b = '0;
                for (int k = 0; k < W; k++) b[k] = r[W-1-k];
                xfer(W, W'(t), b);
            end
        end

        // R5/R6/R7/R9: burst lengths from empty to twice the width
        for (int n = 0; n <= 2 * W + 1; n++) begin
            xfer(n, W'(4'b1010), 32'h0000_5A3C);
            xfer(n, W'(4'b0111), 32'h0000_C3A5 ^ 32'(n));
        end

        // R8: data held after the strobe until the next transfer
        held_rx = rx_data;
        wait_n(20);
        check(rx_data == held_rx, "R8 data held", int'(rx_data), int'(held_rx));

        // R10: clock and data activity while deselected is ignored
        held = sdo;
        p0 = pulses;
        for (int k = 0; k < 3; k++) begin
            sdi = ~sdi;
            sck = 1'b1; wait_n(SETTLE);
            sck = 1'b0; wait_n(SETTLE);
        end
        wait_n(SETTLE);
        check(sdo == held, "R10 sdo held", int'(sdo), int'(held));
        check(pulses == p0, "R10 no strobe", pulses - p0, 0);
        xfer(2, W'(4'b1100), 32'h0000_0002);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_LIM) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_LIM, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule